// File: doc/BRIEF.md
# Horizontal Sync and Back-Porch Generator

This block turns a clean, clock-synchronous composite sync stream (active low) into two regenerated timing pulses. The first is a horizontal sync pulse issued once per scan line. The second is a back-porch gate that an external black-level clamp can use. The horizontal pulse starts on a falling sync edge. An interval guard ignores the extra falling edges that equalizing and serration pulses produce at half-line spacing during field blanking, so the output stays a steady once-per-line train through the blanking interval. The back-porch gate starts on every rising sync edge and covers the quiet part of the line that follows the sync tip.

Every interval is a whole number of "units": the horizontal pulse width, the guard window and the porch width. A unit lasts `scale` clock cycles, and `scale` is a port. One value therefore retunes all three intervals together, and the line rate the block accepts is inversely proportional to it. With the default loads and `scale` set to the number of clock cycles per microsecond, the pulse is 5 µs, the guard is 48 µs and the porch gate is 4 µs, which suits a 64 µs line.

Top module: `hsync_bp_gen`

## Requirements
- R1: A synchronous active-high reset drives `hsync_n` and `bporch_n` high (inactive) from the first clock edge at which it is sampled, and clears the guard. The first falling sync edge after reset is therefore accepted, however recently an edge was accepted before the reset.
- R2: When a clock edge first samples `csync_n` low after it was high, and that falling edge is accepted, `hsync_n` goes low at that same edge. `hsync_n` never falls at any other time.
- R3: Each `hsync_n` low pulse lasts exactly `HS_UNITS` × S clock cycles, where S is the effective scale (see R7).
- R4: A falling edge sampled G = `GUARD_UNITS` × S cycles or fewer after the last accepted falling edge is ignored and produces no `hsync_n` pulse. A falling edge sampled G + 1 cycles or more after it is accepted.
- R5: When a clock edge first samples `csync_n` high after it was low, `bporch_n` goes low at that same edge. This applies to every rising edge, including the half-line ones during field blanking. `bporch_n` never falls at any other time.
- R6: `bporch_n` stays low for `BP_UNITS` × S cycles counted from the most recent rising edge. A rising edge that arrives while the gate is still low restarts the count, and the gate stays low without a gap.
- R7: All three intervals scale linearly with the `scale` input. The effective scale S equals `scale`, except that `scale` = 0 acts as S = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | input | 1 | Composite sync, active low, synchronous to `clk` |
| scale | input | SCALE_W | Clock cycles per timing unit (0 acts as 1) |
| hsync_n | output | 1 | Regenerated horizontal sync, active low |
| bporch_n | output | 1 | Back-porch clamp gate, active low |

## Verification
A guard timer stuck busy shows up as a missing `hsync_n` pulse on the next full line, at most one line period after the fault. A guard that expires early lets a mid-line pulse through on the first half-line edge of field blanking. A wrong unit or sub-unit count in any timer makes a pulse too short or too long, and the error is visible at that pulse's trailing edge. A lost or inverted edge-detector register moves the start of a pulse, or starts pulses from the wrong polarity, within one cycle of the sync edge. The bench predicts every pulse's start cycle and width from the stimulus and the requirements. It runs full lines, equalizing and serration groups, the exact guard boundary, a porch restart, a re-arm after reset, and three scale settings, one of them zero.

// File: rtl/hsbp_pkg.sv
`timescale 1ns/1ps
package hsbp_pkg;

    // One monostable per role; the enum value is the slot in the timer array.
    typedef enum logic [1:0] {
        TMR_HSYNC = 2'd0,
        TMR_GUARD = 2'd1,
        TMR_PORCH = 2'd2
    } timer_e;

    localparam int NUM_TIMERS = 3;

    // Edge events seen on the composite sync input in one cycle.
    typedef struct packed {
        logic fall;
        logic rise;
    } sync_edges_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hsbp_edge.sv
`timescale 1ns/1ps
module hsbp_edge
    import hsbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        csync_n,
    output sync_edges_t edges
);

    logic csync_q;

    // Idle level of the sync line is high, so reset to high.
    always_ff @(posedge clk) begin
        if (rst) begin
            csync_q <= 1'b1;
        end else begin
            csync_q <= csync_n;
        end
    end

    always_comb begin
        edges.fall = csync_q & ~csync_n;
        edges.rise = ~csync_q & csync_n;
    end

endmodule

// File: rtl/hsbp_timer.sv
`timescale 1ns/1ps
module hsbp_timer #(
    parameter int                SCALE_W = 8,
    parameter int                UNIT_W  = 6,
    parameter logic [UNIT_W-1:0] LOAD    = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [SCALE_W-1:0] scale,
    output logic               busy
);

    localparam logic [UNIT_W-1:0] LOAD_EFF  = (LOAD == '0) ? UNIT_W'(1) : LOAD;
    localparam logic [UNIT_W-1:0] LOAD_LAST = LOAD_EFF - UNIT_W'(1);

    logic [SCALE_W-1:0] sub_q;
    logic [UNIT_W-1:0]  unit_q;
    logic [SCALE_W-1:0] sub_top;

    // Cycles per unit minus one; a zero scale behaves as one cycle per unit.
    assign sub_top = (scale == '0) ? '0 : scale - SCALE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            sub_q  <= '0;
            unit_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            sub_q  <= sub_top;
            unit_q <= LOAD_LAST;
        end else if (busy) begin
            if (sub_q == '0) begin
                if (unit_q == '0) begin
                    busy <= 1'b0;
                end else begin
                    unit_q <= unit_q - UNIT_W'(1);
                    sub_q  <= sub_top;
                end
            end else begin
                sub_q <= sub_q - SCALE_W'(1);
            end
        end
    end

endmodule

// File: rtl/hsync_bp_gen.sv
`timescale 1ns/1ps
module hsync_bp_gen
    import hsbp_pkg::*;
#(
    parameter int SCALE_W     = 8,
    parameter int HS_UNITS    = 5,
    parameter int GUARD_UNITS = 48,
    parameter int BP_UNITS    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               csync_n,
    input  logic [SCALE_W-1:0] scale,
    output logic               hsync_n,
    output logic               bporch_n
);

    localparam int MAX_UNITS = max3(HS_UNITS, GUARD_UNITS, BP_UNITS);
    localparam int UNIT_W    = $clog2(MAX_UNITS + 1);

    function automatic logic [UNIT_W-1:0] load_of(input int idx);
        case (idx)
            int'(TMR_HSYNC): return UNIT_W'(HS_UNITS);
            int'(TMR_GUARD): return UNIT_W'(GUARD_UNITS);
            default:         return UNIT_W'(BP_UNITS);
        endcase
    endfunction

    sync_edges_t           edges;
    logic                  accept;
    logic [NUM_TIMERS-1:0] start_v;
    logic [NUM_TIMERS-1:0] busy_v;

    hsbp_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .csync_n (csync_n),
        .edges   (edges)
    );

    // A falling edge counts only once the guard window has run out.
    assign accept = edges.fall & ~busy_v[int'(TMR_GUARD)];

    always_comb begin
        start_v                   = '0;
        start_v[int'(TMR_HSYNC)] = accept;
        start_v[int'(TMR_GUARD)] = accept;
        start_v[int'(TMR_PORCH)] = edges.rise;
    end

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        hsbp_timer #(
            .SCALE_W (SCALE_W),
            .UNIT_W  (UNIT_W),
            .LOAD    (load_of(i))
        ) u_tmr (
            .clk   (clk),
            .rst   (rst),
            .start (start_v[i]),
            .scale (scale),
            .busy  (busy_v[i])
        );
    end

    assign hsync_n  = ~busy_v[int'(TMR_HSYNC)];
    assign bporch_n = ~busy_v[int'(TMR_PORCH)];

endmodule

// File: rtl/hsync_bp_gen_chk.sv
`timescale 1ns/1ps
module hsync_bp_gen_chk #(
    parameter int SCALE_W     = 8,
    parameter int HS_UNITS    = 5,
    parameter int GUARD_UNITS = 48,
    parameter int BP_UNITS    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               csync_n,
    input logic [SCALE_W-1:0] scale,
    input logic               hsync_n,
    input logic               bporch_n
);

    int unsigned eff;
    int unsigned hs_low;
    int unsigned bp_low;
    int unsigned since;
    logic        armed;

    assign eff = (scale == '0) ? 32'd1 : 32'(scale);

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_low <= 0;
            bp_low <= 0;
            since  <= 0;
            armed  <= 1'b0;
        end else begin
            hs_low <= hsync_n  ? 0 : hs_low + 1;
            bp_low <= bporch_n ? 0 : bp_low + 1;
            if ($fell(hsync_n)) begin
                since <= 1;
                armed <= 1'b1;
            end else if (since != 32'hFFFF_FFFF) begin
                since <= since + 1;
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (hsync_n && bporch_n));

    // R2
    hs_from_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> !$past(csync_n));

    // R3
    hs_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> (hs_low == 32'(HS_UNITS) * eff));

    // R4
    guard_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(hsync_n) && armed) |-> (since > 32'(GUARD_UNITS) * eff));

    // R5
    bp_from_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bporch_n) |-> $past(csync_n));

    // R6
    bp_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bporch_n) |-> (bp_low >= 32'(BP_UNITS) * eff));

endmodule

bind hsync_bp_gen hsync_bp_gen_chk #(
    .SCALE_W     (SCALE_W),
    .HS_UNITS    (HS_UNITS),
    .GUARD_UNITS (GUARD_UNITS),
    .BP_UNITS    (BP_UNITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .csync_n  (csync_n),
    .scale    (scale),
    .hsync_n  (hsync_n),
    .bporch_n (bporch_n)
);

// File: tb/hsync_bp_gen_bench.sv
`timescale 1ns/1ps
module hsync_bp_gen_bench;

    localparam int SW   = 8;
    localparam int HS_U = 5;
    localparam int GD_U = 48;
    localparam int BP_U = 4;

    typedef struct {
        int start;
        int width;
    } pulse_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csync_n = 1'b1;
    logic [SW-1:0] scale = 8'd4;
    logic          hsync_n;
    logic          bporch_n;

    int     cyc = 0;
    int     checks = 0;
    int     fails = 0;
    bit     done = 1'b0;
    pulse_t hs_q[$];
    pulse_t bp_q[$];

    int  s_eff = 4;
    int  last_acc = 0;
    bit  armed = 1'b0;
    bit  cs_model = 1'b1;
    int  bp_end = -1;
    bit  hs_prev = 1'b1;
    bit  bp_prev = 1'b1;
    int  hs_start = 0;
    int  bp_start = 0;
    string phase = "base";

    hsync_bp_gen #(
        .SCALE_W     (SW),
        .HS_UNITS    (HS_U),
        .GUARD_UNITS (GD_U),
        .BP_UNITS    (BP_U)
    ) u_hsync_bp_gen (
        .clk      (clk),
        .rst      (rst),
        .csync_n  (csync_n),
        .scale    (scale),
        .hsync_n  (hsync_n),
        .bporch_n (bporch_n)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, phase, what, act, exp);
        end
    endtask

    // Monitor: measure each output pulse and compare with the scoreboard.
    always @(negedge clk) begin
        if (rst) begin
            hs_prev = 1'b1;
            bp_prev = 1'b1;
        end else begin
            if (hs_prev && !hsync_n) hs_start = cyc;
            if (!hs_prev && hsync_n) begin
                if (hs_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected hsync pulse at", hs_start, -1);
                end else begin
                    pulse_t p;
                    p = hs_q.pop_front();
                    check(hs_start == p.start, "R2", "hsync start", hs_start, p.start);
                    check(cyc - hs_start == p.width, "R3", "hsync width", cyc - hs_start, p.width);
                end
            end
            if (bp_prev && !bporch_n) bp_start = cyc;
            if (!bp_prev && bporch_n) begin
                if (bp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected porch pulse at", bp_start, -1);
                end else begin
                    pulse_t p;
                    p = bp_q.pop_front();
                    check(bp_start == p.start, "R5", "porch start", bp_start, p.start);
                    check(cyc - bp_start == p.width, "R6", "porch width", cyc - bp_start, p.width);
                end
            end
            hs_prev = hsync_n;
            bp_prev = bporch_n;
        end
    end

    // Driver: change csync_n and push the pulses the requirements predict.
    task automatic drive(input bit v);
        int e;
        @(negedge clk);
        e = cyc + 1;
        csync_n = v;
        if (cs_model && !v) begin
            if (!armed || (e - last_acc) > GD_U * s_eff) begin
                hs_q.push_back('{start: e, width: HS_U * s_eff});
                last_acc = e;
                armed = 1'b1;
            end
        end else if (!cs_model && v) begin
            if (bp_q.size() > 0 && e <= bp_end) begin
                bp_q[$].width = e + BP_U * s_eff - bp_q[$].start;
            end else begin
                bp_q.push_back('{start: e, width: BP_U * s_eff});
            end
            bp_end = e + BP_U * s_eff;
        end
        cs_model = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One sync period: low for lo units, then high for hi units.
    task automatic period(input int lo, input int hi);
        drive(1'b0);
        idle(lo * s_eff - 1);
        drive(1'b1);
        idle(hi * s_eff - 1);
    endtask

    task automatic drain();
        int n = 0;
        while ((hs_q.size() != 0 || bp_q.size() != 0) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(hs_q.size() == 0, "R4", "hsync pulses still expected", hs_q.size(), 0);
        check(bp_q.size() == 0, "R6", "porch pulses still expected", bp_q.size(), 0);
    endtask

    task automatic do_reset(input int sc);
        @(negedge clk);
        rst = 1'b1;
        scale = SW'(sc);
        csync_n = 1'b1;
        cs_model = 1'b1;
        armed = 1'b0;
        bp_end = -1;
        s_eff = (sc == 0) ? 1 : sc;
        idle(2);
        check(hsync_n == 1'b1, "R1", "hsync_n in reset", hsync_n, 1);
        check(bporch_n == 1'b1, "R1", "bporch_n in reset", bporch_n, 1);
        rst = 1'b0;
        idle(3);
        check(hsync_n == 1'b1, "R1", "hsync_n after reset", hsync_n, 1);
        check(bporch_n == 1'b1, "R1", "bporch_n after reset", bporch_n, 1);
    endtask

    task automatic field_blank();
        for (int i = 0; i < 6; i++) period(2, 30);
        for (int i = 0; i < 5; i++) period(27, 5);
        for (int i = 0; i < 5; i++) period(2, 30);
    endtask

    initial begin
        int g;
        // Normal lines and a field blanking group at scale 4.
        phase = "lines";
        do_reset(4);
        for (int i = 0; i < 4; i++) period(5, 59);
        phase = "blanking";
        field_blank();
        for (int i = 0; i < 3; i++) period(5, 59);
        drain();

        // R4 boundary: a fall exactly G cycles after is ignored, G+1 is taken.
        phase = "guard";
        g = GD_U * s_eff;
        drive(1'b0); idle(9); drive(1'b1); idle(g - 11);
        drive(1'b0); idle(4); drive(1'b1); idle(40);
        drain();
        drive(1'b0); idle(9); drive(1'b1); idle(g - 10);
        drive(1'b0); idle(19); drive(1'b1); idle(g);
        drain();

        // R6 restart: a second rising edge inside the porch gate.
        phase = "restart";
        drive(1'b0); idle(19); drive(1'b1); idle(2);
        drive(1'b0); idle(2); drive(1'b1); idle(60);
        drain();

        // R1 re-arm: reset inside the guard window, then fall at once.
        phase = "rearm";
        drive(1'b0); idle(19); drive(1'b1); idle(30);
        drain();
        do_reset(4);
        drive(1'b0); idle(19); drive(1'b1); idle(40);
        drain();

        // R7: other scale values, including zero acting as one.
        phase = "R7 scale 2";
        do_reset(2);
        for (int i = 0; i < 3; i++) period(5, 59);
        for (int i = 0; i < 4; i++) period(2, 30);
        for (int i = 0; i < 2; i++) period(5, 59);
        drain();
        phase = "R7 scale 0";
        do_reset(0);
        for (int i = 0; i < 3; i++) period(5, 59);
        for (int i = 0; i < 4; i++) period(27, 5);
        for (int i = 0; i < 2; i++) period(5, 59);
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule